// File: doc/BRIEF.md
# Block-Transfer SPI Master

This block is a half-duplex SPI master. Software programs a byte count, a clock divisor, a target device, a lane mode and a direction, then sets a start bit. The block moves that number of bytes through one 32-bit-wide word FIFO. In write mode software fills the FIFO and the engine drains it onto the wire. In read mode the engine fills it from the wire and software drains it. The transfer stalls with SCLK idle whenever the FIFO has nothing to send or no room to receive.

Bytes sit little-endian in each FIFO word. A final partial word supplies or receives only the bytes still owed, and the unused upper bytes of a received partial word read as zero. Each byte goes out or comes in most significant part first, either one bit per SCLK on a single line (SPI mode 0) or one nibble per SCLK on four lines. The selected chip select is asserted at start and stays asserted after the transfer ends. It is released only when software writes 0 to the chip-select register, so a caller can chain several transfers into one transaction.

Register map (word index on `reg_addr`): 0 control, 1 chip select, 2 byte count, 3 FIFO data, 4 status.

Top module: `spi_blk_master`

## Requirements
- R1: After reset the control, chip-select and status registers read 0, every `cs_n` is 1, `sclk` is 0 and `io_oe` is 0.
- R2: The control register holds the SCLK divisor in bits 2:0, the device number in bits 7:6, quad lanes in bit 12 (1 = four lines) and write direction in bit 13 (1 = write). Writing bit 15 as 1 while idle starts a transfer. Bit 15 reads 1 while a transfer is in progress, and the other fields read back as written.
- R3: The byte-count register keeps bits 20:0 of a write and reads 0 in bits 31:21. A transfer moves exactly that many bytes.
- R4: The FIFO holds FIFO_DEPTH words (default 8). Status bit 0 reads 1 exactly when it is full. A push into a full FIFO is dropped, and a pop of an empty FIFO changes nothing.
- R5: In single-line write mode each byte leaves on `io_out[0]`, MSB first. SCLK idles low and data changes only while SCLK is low. The bytes of each FIFO word are sent from the lowest byte upward, and only the remaining bytes of a last word are sent.
- R6: In quad write mode each byte leaves on `io_out[3:0]` as the high nibble, then the low nibble, one nibble per SCLK, with `io_oe` = 4'hF during the transfer.
- R7: In single-line read mode the block samples `io_in[1]` on each rising SCLK and packs bytes little-endian into FIFO words. A final partial word has zero upper bytes.
- R8: In quad read mode the block samples `io_in[3:0]` as a nibble (high nibble first) on each rising SCLK and drives `io_oe` = 0 during the transfer.
- R9: The SCLK period is 2^(divisor+1) system clocks.
- R10: When the last byte completes, busy clears and `xfer_done` is high for exactly one cycle. A start with a byte count of 0 gives the pulse at once and moves no data.
- R11: A start sets chip-select bit 0 and drives only `cs_n[device]` low. This stays in place after the transfer ends, until software writes 0 to chip-select bit 0.
- R12: A write transfer holds SCLK idle while the FIFO is empty and bytes remain. A read transfer holds SCLK idle while a finished word waits for a full FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at index 3) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| xfer_done | output | 1 | One-cycle pulse at transfer end |
| sclk | output | 1 | SPI clock, idles low |
| cs_n | output | NUM_CS | Active-low chip selects |
| io_out | output | 4 | Data out; bit 0 is the single-line output |
| io_oe | output | 4 | Output enables per data line |
| io_in | input | 4 | Data in; bit 1 is the single-line input |

## Verification
Write transfers carry bytes such as 0x11, 0x22, 0x33 and 0x44 in one word, so a reversed byte order or bit order shows up as a wrong byte in the scoreboard. Reads use asymmetric values such as 0x5A, 0x01 and 0x80 and end on partial words, which separates MSB-first from LSB-first sampling and shows whether unused upper bytes are cleared. Both lane widths are run at two divisor settings, and the measured rising-edge spacing confirms the clock divider. Stall cases start a write with the FIFO short of data and a read longer than the FIFO. These show that SCLK stops, busy holds and the data resumes intact, and they separate true flow control from silent overrun.

// File: rtl/spi_blk_pkg.sv
`timescale 1ns/1ps
package spi_blk_pkg;
    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_CS   = 3'd1;
    localparam logic [2:0] ADDR_LEN  = 3'd2;
    localparam logic [2:0] ADDR_FIFO = 3'd3;
    localparam logic [2:0] ADDR_STAT = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_NEXT,
        ST_PUSH
    } eng_state_e;
endpackage

// File: rtl/spi_blk_fifo.sv
`timescale 1ns/1ps
module spi_blk_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full    = (p_q.cnt == (AW+1)'(DEPTH));
    assign empty   = (p_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem_q[p_q.rp];

    always_comb begin
        p_d = p_q;
        if (do_push) p_d.wp = p_q.wp + 1'b1;
        if (do_pop)  p_d.rp = p_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[p_q.wp] <= wdata;
    end
endmodule

// File: rtl/spi_blk_div.sv
`timescale 1ns/1ps
module spi_blk_div #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = (1 << SEL_W) - 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] limit;

    assign limit = (CW'(1) << sel) - 1'b1;
    assign tick  = en && (cnt_q == limit);

    always_comb begin
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_blk_engine.sv
`timescale 1ns/1ps
module spi_blk_engine
    import spi_blk_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 21,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    input  logic              quad,
    input  logic              wr_dir,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] fifo_rdata,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    output logic              fifo_pop,
    output logic              fifo_push,
    output logic [WORD_W-1:0] fifo_wdata,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);
    localparam int BPW   = WORD_W / 8;
    localparam int BIX_W = $clog2(BPW);

    typedef struct packed {
        eng_state_e        st;
        logic [LEN_W-1:0]  left;
        logic [BIX_W-1:0]  bidx;
        logic [2:0]        step;
        logic [7:0]        sb;
        logic [WORD_W-1:0] word;
        logic              sclk;
        logic              quad;
        logic              wr;
        logic              done;
    } eng_t;

    eng_t e_d, e_q;
    logic tick, last_step;

    spi_blk_div #(.SEL_W(SEL_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (e_q.st == ST_SHIFT),
        .sel  (sel),
        .tick (tick)
    );

    assign last_step = e_q.quad ? (e_q.step == 3'd1) : (e_q.step == 3'd7);

    always_comb begin
        e_d       = e_q;
        e_d.done  = 1'b0;
        fifo_pop  = 1'b0;
        fifo_push = 1'b0;
        case (e_q.st)
            ST_IDLE: if (start) begin
                e_d.quad = quad;
                e_d.wr   = wr_dir;
                e_d.bidx = '0;
                e_d.word = '0;
                e_d.left = len;
                e_d.sclk = 1'b0;
                if (len == '0) e_d.done = 1'b1;
                else           e_d.st   = ST_LOAD;
            end
            ST_LOAD: begin
                e_d.step = '0;
                if (!e_q.wr) begin
                    e_d.sb = '0;
                    e_d.st = ST_SHIFT;
                end else if (e_q.bidx != '0) begin
                    e_d.sb = e_q.word[8*e_q.bidx +: 8];
                    e_d.st = ST_SHIFT;
                end else if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    e_d.word = fifo_rdata;
                    e_d.sb   = fifo_rdata[7:0];
                    e_d.st   = ST_SHIFT;
                end
            end
            ST_SHIFT: if (tick) begin
                if (!e_q.sclk) begin
                    e_d.sclk = 1'b1;
                    if (!e_q.wr)
                        e_d.sb = e_q.quad ? {e_q.sb[3:0], io_in} : {e_q.sb[6:0], io_in[1]};
                end else begin
                    e_d.sclk = 1'b0;
                    e_d.step = e_q.step + 1'b1;
                    if (e_q.wr)
                        e_d.sb = e_q.quad ? {e_q.sb[3:0], 4'h0} : {e_q.sb[6:0], 1'b0};
                    if (last_step) e_d.st = ST_NEXT;
                end
            end
            ST_NEXT: begin
                e_d.left = e_q.left - 1'b1;
                e_d.bidx = e_q.bidx + 1'b1;
                if (!e_q.wr) e_d.word[8*e_q.bidx +: 8] = e_q.sb;
                if (!e_q.wr && (e_q.bidx == BIX_W'(BPW-1) || e_q.left == LEN_W'(1))) begin
                    e_d.st = ST_PUSH;
                end else if (e_q.left == LEN_W'(1)) begin
                    e_d.st   = ST_IDLE;
                    e_d.done = 1'b1;
                end else begin
                    e_d.st = ST_LOAD;
                end
            end
            ST_PUSH: if (!fifo_full) begin
                fifo_push = 1'b1;
                e_d.word  = '0;
                if (e_q.left == '0) begin
                    e_d.st   = ST_IDLE;
                    e_d.done = 1'b1;
                end else begin
                    e_d.st = ST_LOAD;
                end
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{st: ST_IDLE, default: '0};
        else        e_q <= e_d;
    end

    assign busy       = (e_q.st != ST_IDLE);
    assign done       = e_q.done;
    assign sclk       = e_q.sclk;
    assign fifo_wdata = e_q.word;

    always_comb begin
        io_out = 4'h0;
        io_oe  = 4'h0;
        if (busy) begin
            if (e_q.wr) begin
                io_out = e_q.quad ? e_q.sb[7:4] : {3'b000, e_q.sb[7]};
                io_oe  = e_q.quad ? 4'hF : 4'h1;
            end else begin
                io_oe  = e_q.quad ? 4'h0 : 4'h1;
            end
        end
    end
endmodule

// File: rtl/spi_blk_master.sv
`timescale 1ns/1ps
module spi_blk_master
    import spi_blk_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int NUM_CS     = 3,
    parameter int LEN_W      = 21,
    parameter int SEL_W      = 3,
    parameter int DEV_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              xfer_done,
    output logic              sclk,
    output logic [NUM_CS-1:0] cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [DEV_W-1:0] dev;
        logic             quad;
        logic             wr;
        logic             cs;
        logic [DEV_W-1:0] cs_dev;
        logic [LEN_W-1:0] len;
    } regs_t;

    regs_t r_d, r_q;
    logic eng_busy, start;
    logic eng_pop, eng_push, sw_pop, sw_push;
    logic fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [WORD_W-1:0] eng_wdata, fifo_rdata, fifo_wdata;

    assign start   = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[15] && !eng_busy;
    assign sw_push = reg_wr && (reg_addr == ADDR_FIFO);
    assign sw_pop  = reg_rd && (reg_addr == ADDR_FIFO);

    always_comb begin
        r_d = r_q;
        if (reg_wr && reg_addr == ADDR_CTRL && !eng_busy) begin
            r_d.sel  = reg_wdata[SEL_W-1:0];
            r_d.dev  = reg_wdata[6 +: DEV_W];
            r_d.quad = reg_wdata[12];
            r_d.wr   = reg_wdata[13];
        end
        if (start) begin
            r_d.cs     = 1'b1;
            r_d.cs_dev = reg_wdata[6 +: DEV_W];
        end
        if (reg_wr && reg_addr == ADDR_CS && !reg_wdata[0]) r_d.cs = 1'b0;
        if (reg_wr && reg_addr == ADDR_LEN) r_d.len = reg_wdata[LEN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[SEL_W-1:0]  = r_q.sel;
                reg_rdata[6 +: DEV_W] = r_q.dev;
                reg_rdata[12]         = r_q.quad;
                reg_rdata[13]         = r_q.wr;
                reg_rdata[15]         = eng_busy;
            end
            ADDR_CS:   reg_rdata[0]         = r_q.cs;
            ADDR_LEN:  reg_rdata[LEN_W-1:0] = r_q.len;
            ADDR_FIFO: reg_rdata            = fifo_rdata;
            ADDR_STAT: reg_rdata[0]         = fifo_full;
            default:   reg_rdata            = '0;
        endcase
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !(r_q.cs && r_q.cs_dev == DEV_W'(i));
    end

    assign fifo_push  = eng_push | sw_push;
    assign fifo_pop   = eng_pop | sw_pop;
    assign fifo_wdata = eng_push ? eng_wdata : reg_wdata;

    spi_blk_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (fifo_push),
        .wdata(fifo_wdata),
        .pop  (fifo_pop),
        .rdata(fifo_rdata),
        .full (fifo_full),
        .empty(fifo_empty)
    );

    spi_blk_engine #(.WORD_W(WORD_W), .LEN_W(LEN_W), .SEL_W(SEL_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .len       (r_q.len),
        .quad      (reg_wdata[12]),
        .wr_dir    (reg_wdata[13]),
        .sel       (r_q.sel),
        .fifo_rdata(fifo_rdata),
        .fifo_empty(fifo_empty),
        .fifo_full (fifo_full),
        .fifo_pop  (eng_pop),
        .fifo_push (eng_push),
        .fifo_wdata(eng_wdata),
        .busy      (eng_busy),
        .done      (xfer_done),
        .sclk      (sclk),
        .io_out    (io_out),
        .io_oe     (io_oe),
        .io_in     (io_in)
    );
endmodule

// File: rtl/spi_blk_master_chk.sv
`timescale 1ns/1ps
module spi_blk_master_chk
    import spi_blk_pkg::*;
#(
    parameter int NUM_CS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              sclk,
    input logic [NUM_CS-1:0] cs_n,
    input logic              cs_sel,
    input logic [3:0]        io_oe,
    input logic              wr_mode,
    input logic              quad_mode,
    input logic              fifo_full,
    input logic              fifo_push,
    input logic              fifo_pop,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_wdata
);
    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_cs_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_cs_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_sel && !(reg_wr && reg_addr == ADDR_CS && !reg_wdata[0])) |=> cs_sel);

    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && fifo_push && !fifo_pop) |=> fifo_full);

    p_quad_rd_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_mode && quad_mode) |-> (io_oe == 4'h0));
endmodule

bind spi_blk_master spi_blk_master_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (eng_busy),
    .done     (xfer_done),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .cs_sel   (r_q.cs),
    .io_oe    (io_oe),
    .wr_mode  (r_q.wr),
    .quad_mode(r_q.quad),
    .fifo_full(fifo_full),
    .fifo_push(fifo_push),
    .fifo_pop (fifo_pop),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata)
);

// File: tb/sim_spi_blk_master.sv
`timescale 1ns/1ps
module sim_spi_blk_master;
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_CS   = 3'd1;
    localparam logic [2:0] A_LEN  = 3'd2;
    localparam logic [2:0] A_FIFO = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xfer_done, sclk;
    logic [2:0]  cs_n;
    logic [3:0]  io_out, io_oe;
    logic [3:0]  io_in = 4'h0;

    int total = 0, bad = 0;
    int done_cnt = 0;
    int rises = 0;
    time t_rise0, t_rise1;
    logic sclk_prev = 1'b0;
    bit   mon_on = 1'b0, mon_quad = 1'b0;
    int   mon_steps = 0;
    logic [7:0] mon_acc = '0;
    logic [7:0] exp_q[$];
    logic [7:0] slv_q[$];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_blk_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_done(xfer_done), .sclk(sclk), .cs_n(cs_n),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_all();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor: counts rising SCLK edges and compares shifted-out bytes
    always @(negedge clk) begin
        if (xfer_done) done_cnt++;
        if (sclk && !sclk_prev) begin
            if (rises == 0) t_rise0 = $time;
            if (rises == 1) t_rise1 = $time;
            rises++;
            if (mon_on) begin
                mon_acc = mon_quad ? {mon_acc[3:0], io_out} : {mon_acc[6:0], io_out[0]};
                mon_steps++;
                if (mon_steps == (mon_quad ? 2 : 8)) begin
                    mon_steps = 0;
                    if (exp_q.size() == 0) check("R5 extra byte", {24'h0, mon_acc}, 32'hxxxx_xxxx);
                    else check(mon_quad ? "R6 quad byte" : "R5 serial byte", {24'h0, mon_acc}, {24'h0, exp_q.pop_front()});
                end
            end
        end
        sclk_prev = sclk;
    end

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] ctl(int sel, int dev, bit quad, bit wr, bit go);
        return 32'(sel) | (32'(dev) << 6) | (32'(quad) << 12) | (32'(wr) << 13) | (32'(go) << 15);
    endfunction

    task automatic wait_done(input string req);
        int n0 = done_cnt;
        bit ok = 1'b0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (done_cnt > n0) begin ok = 1'b1; break; end
        end
        check(req, 32'(ok), 32'd1);
    endtask

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // slave model: presents bytes on io_in, advancing after each falling SCLK
    task automatic slave_run(input bit quad, input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = slv_q.pop_front();
            for (int s = 0; s < (quad ? 2 : 8); s++) begin
                io_in = quad ? ((s == 0) ? b[7:4] : b[3:0]) : {2'b00, b[7-s], 1'b0};
                do @(negedge clk); while (sclk !== 1'b1);
                do @(negedge clk); while (sclk !== 1'b0);
            end
        end
    endtask

    initial begin
        wait_cycles(150000);
        check("watchdog", 32'd0, 32'd1);
        finish_all();
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  bb;
        int d0, r0;

        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(2);

        // R1 reset state
        bus_rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
        bus_rd(A_CS, v);   check("R1 cs reg", v, 32'h0);
        bus_rd(A_STAT, v); check("R1 status", v, 32'h0);
        check("R1 pins", {25'h0, cs_n, sclk, io_oe}, {25'h0, 3'b111, 1'b0, 4'h0});

        // R2 field readback
        bus_wr(A_CTRL, ctl(5, 2, 1, 0, 0));
        bus_rd(A_CTRL, v); check("R2 ctrl readback", v, 32'h0000_1085);

        // R4 FIFO full and drop
        for (int i = 0; i < 9; i++) bus_wr(A_FIFO, 32'hA000_0000 + 32'(i));
        bus_rd(A_STAT, v); check("R4 full flag", v, 32'h1);
        for (int i = 0; i < 8; i++) begin
            bus_rd(A_FIFO, v); check("R4 fifo order", v, 32'hA000_0000 + 32'(i));
        end
        bus_rd(A_STAT, v); check("R4 not full", v, 32'h0);
        bus_rd(A_FIFO, v);
        bus_wr(A_FIFO, 32'h0000_00AA);
        bus_rd(A_FIFO, v); check("R4 empty pop ignored", v, 32'h0000_00AA);

        // R5 serial write, partial last word, R11 chip select, R9 period
        exp_q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hAA};
        bus_wr(A_LEN, 32'd5);
        bus_wr(A_FIFO, 32'h4433_2211);
        bus_wr(A_FIFO, 32'h0000_00AA);
        mon_on = 1'b1; mon_quad = 1'b0; mon_steps = 0; rises = 0;
        bus_wr(A_CTRL, ctl(0, 1, 0, 1, 1));
        check("R11 cs low at start", {29'h0, cs_n}, 32'h5);
        bus_rd(A_CTRL, v); check("R2 busy bit", {31'h0, v[15]}, 32'h1);
        wait_done("R10 write done");
        check("R5 all bytes sent", exp_q.size(), 0);
        check("R9 period div0", 32'(t_rise1 - t_rise0), 32'd10);
        bus_rd(A_CTRL, v); check("R10 busy clear", {31'h0, v[15]}, 32'h0);
        bus_rd(A_CS, v); check("R11 cs held after done", v, 32'h1);
        check("R11 cs pin held", {29'h0, cs_n}, 32'h5);
        bus_wr(A_CS, 32'h0);
        check("R11 cs released", {29'h0, cs_n}, 32'h7);

        // R6 quad write, R9 period at divisor 2
        exp_q = '{8'hA1, 8'hB2, 8'hC3};
        bus_wr(A_LEN, 32'd3);
        bus_wr(A_FIFO, 32'h00C3_B2A1);
        mon_quad = 1'b1; mon_steps = 0; rises = 0;
        bus_wr(A_CTRL, ctl(2, 0, 1, 1, 1));
        wait (rises >= 1); @(negedge clk);
        check("R6 quad oe", {28'h0, io_oe}, 32'hF);
        wait_done("R10 quad write done");
        check("R6 all bytes sent", exp_q.size(), 0);
        check("R9 period div2", 32'(t_rise1 - t_rise0), 32'd40);
        check("R6 rises", rises, 6);
        bus_wr(A_CS, 32'h0);

        // R3 count upper bits ignored
        bus_wr(A_LEN, 32'hFFE0_0002);
        bus_rd(A_LEN, v); check("R3 len readback", v, 32'h2);
        exp_q = '{8'hEF, 8'hBE};
        bus_wr(A_FIFO, 32'h0000_BEEF);
        mon_quad = 1'b0; mon_steps = 0; rises = 0;
        bus_wr(A_CTRL, ctl(0, 2, 0, 1, 1));
        check("R11 dev2 cs", {29'h0, cs_n}, 32'h3);
        wait_done("R3 done");
        check("R3 bit count", rises, 16);
        check("R3 bytes", exp_q.size(), 0);
        bus_wr(A_CS, 32'h0);

        // R10 zero-length start
        d0 = done_cnt; rises = 0;
        bus_wr(A_LEN, 32'd0);
        bus_wr(A_CTRL, ctl(0, 0, 0, 1, 1));
        wait_cycles(3);
        check("R10 zero len pulse", done_cnt - d0, 1);
        check("R10 zero len no clock", rises, 0);
        bus_wr(A_CS, 32'h0);
        mon_on = 1'b0;

        // R7 serial read with partial word
        slv_q = '{8'h5A, 8'hC3, 8'h01, 8'hFF, 8'h80, 8'h7E};
        bus_wr(A_LEN, 32'd6);
        fork slave_run(1'b0, 6); join_none
        bus_wr(A_CTRL, ctl(1, 0, 0, 0, 1));
        wait_done("R7 read done");
        bus_rd(A_FIFO, v); check("R7 word0", v, 32'hFF01_C35A);
        bus_rd(A_FIFO, v); check("R7 word1 partial", v, 32'h0000_7E80);
        bus_wr(A_CS, 32'h0);

        // R8 quad read
        slv_q = '{8'h12, 8'h34, 8'h56, 8'h78};
        bus_wr(A_LEN, 32'd4);
        rises = 0;
        fork slave_run(1'b1, 4); join_none
        bus_wr(A_CTRL, ctl(0, 1, 1, 0, 1));
        wait (rises >= 1); @(negedge clk);
        check("R8 quad read oe", {28'h0, io_oe}, 32'h0);
        wait_done("R8 read done");
        bus_rd(A_FIFO, v); check("R8 word", v, 32'h7856_3412);
        bus_wr(A_CS, 32'h0);

        // R12 write stall on empty FIFO
        exp_q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
        mon_on = 1'b1; mon_quad = 1'b0; mon_steps = 0; rises = 0;
        bus_wr(A_LEN, 32'd8);
        bus_wr(A_FIFO, 32'h0403_0201);
        bus_wr(A_CTRL, ctl(0, 0, 0, 1, 1));
        wait (rises >= 32);
        wait_cycles(60);
        check("R12 write stalled", rises, 32);
        bus_rd(A_CTRL, v); check("R12 busy during write stall", {31'h0, v[15]}, 32'h1);
        bus_wr(A_FIFO, 32'h0807_0605);
        wait_done("R12 write resumed");
        check("R12 write bytes", exp_q.size(), 0);
        bus_wr(A_CS, 32'h0);
        mon_on = 1'b0;

        // R12 read stall on full FIFO
        slv_q.delete();
        for (int i = 0; i < 40; i++) begin
            bb = 8'(i * 37 + 5);
            slv_q.push_back(bb);
        end
        rises = 0;
        bus_wr(A_LEN, 32'd40);
        fork slave_run(1'b0, 40); join_none
        bus_wr(A_CTRL, ctl(0, 0, 0, 0, 1));
        wait (rises >= 288);
        wait_cycles(60);
        r0 = rises;
        wait_cycles(60);
        check("R12 read stalled", rises, 288);
        check("R12 read stall stable", rises, r0);
        bus_rd(A_STAT, v); check("R4 full during stall", v, 32'h1);
        for (int w = 0; w < 10; w++) begin
            logic [31:0] e;
            if (w == 8) wait_done("R12 read resumed");
            for (int k = 0; k < 4; k++) e[8*k +: 8] = 8'((4*w + k) * 37 + 5);
            bus_rd(A_FIFO, v); check("R12 read word", v, e);
        end
        bus_wr(A_CS, 32'h0);

        finish_all();
    end
endmodule